// File: doc/BRIEF.md
# Chip Reset Sequencer

This block produces the chip-wide reset and controls when the processor is allowed to run again. Two reset sources start the timed sequence: an external reset pin, counted only after it has stayed high long enough, and a reset control bit from the register file. While a request is present, the register file is held in reset. After the request goes away, a timer counts ticks of the slow clock. When the timer expires, the processor core is released and a one-cycle start strobe marks a boot from address zero.

The length of the timer depends on two things: which source started the reset, and whether system power was present on the last request cycle. A debug soft reset (active low) holds only the processor core. The RTC and test-mux reset also needs the test pin to be high. A sticky flag records a watchdog overflow.

All logic runs on a fast reference clock `clk`. The slow clock arrives as a one-cycle enable, `slow_tick`. `por_n` is the power-on reset of the block's own flops. There is no streaming data path, so every pin is a plain level or pulse.

Top module: `chip_rst_seq`

## Requirements
- R1: The external pin counts as a reset only once it has been high for QUAL_CYC consecutive `clk` cycles. A pulse shorter than that changes no output.
- R2: `regs_rst` and `cpu_rst` are high whenever the qualified pin is high, `rst_bit` is high, or the timer is running.
- R3: `rtc_rst` is high exactly while the qualified pin and `test_pin` are both high. The control bit alone never raises it.
- R4: After a pin-started reset with `sys_pwr` high on the last request cycle, `cpu_start` pulses for exactly one `clk` cycle. The pulse comes on the cycle after the LONG_TICKS-th `slow_tick` that follows the request, and `regs_rst` drops on the same cycle.
- R5: After a reset started only by `rst_bit`, with power present, the release comes after SHORT_TICKS slow ticks. If the pin and the bit request together, the pin's length applies.
- R6: If `sys_pwr` is low on the last request cycle, the release comes after BRN_TICKS slow ticks for either source. `brownout` then reads 1 from the start strobe until the next release. A release with power present sets `brownout` to 0.
- R7: Any request that arrives while the timer is running restarts the count from zero.
- R8: A low `dbg_rst_n` raises `cpu_rst` only. It leaves `regs_rst`, `rtc_rst` and the timer unaffected.
- R9: A `wdt_ovf` pulse sets `wdt_flag` while `wdt_dis` is low. While `wdt_dis` is high, the pulse is ignored.
- R10: Only the qualified reset pin clears `wdt_flag`, and the clear wins over a simultaneous set. A reset from the control bit leaves the flag unchanged.
- R11: After `por_n` is released, the sequencer behaves as after a pin reset with power present: LONG_TICKS slow ticks, then `cpu_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| por_n | input | 1 | Asynchronous power-on reset of the block, active low |
| slow_tick | input | 1 | One-cycle enable marking each slow-clock period |
| rst_pin | input | 1 | External reset pin, active high |
| rst_bit | input | 1 | Reset control bit from the register file, active high |
| test_pin | input | 1 | Test pin; enables RTC and test-mux reset |
| dbg_rst_n | input | 1 | Debug soft reset of the processor core, active low |
| sys_pwr | input | 1 | System power present |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| wdt_dis | input | 1 | Debug watchdog disable |
| regs_rst | output | 1 | Register-file reset |
| rtc_rst | output | 1 | RTC and test-mux reset |
| cpu_rst | output | 1 | Processor-core reset |
| cpu_start | output | 1 | One-cycle strobe: boot from address zero |
| brownout | output | 1 | Last release was in brownout mode |
| wdt_flag | output | 1 | Sticky watchdog-overflow flag |

## Verification
The bench builds the block with QUAL_CYC=4, LONG_TICKS=20, SHORT_TICKS=5 and BRN_TICKS=2, and it issues a slow tick every third clock. With these values, the full power-present wait of R4 and R11 fits in about sixty cycles. This lets the bench cover the boundary between a rejected pulse and a qualified one, all three timer lengths, and a restart part-way through the short timer, each several times within one run. A behavioural model checks every output on every clock.

// File: rtl/chip_rst_seq_pkg.sv
package chip_rst_seq_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PIN  = 2'd1,
    SRC_CTRL = 2'd2
  } req_src_e;

  // Request source and power state -> length class for the timer
  typedef enum logic [1:0] {
    LEN_LONG  = 2'd0,
    LEN_SHORT = 2'd1,
    LEN_BRN   = 2'd2
  } len_cls_e;

  function automatic len_cls_e pick_len(input req_src_e src, input logic pwr);
    if (!pwr)           return LEN_BRN;
    if (src == SRC_PIN) return LEN_LONG;
    return LEN_SHORT;
  endfunction
endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
  parameter int QUAL_CYC = 100
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin,
  output logic qual
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(QUAL_CYC);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            hi_cnt <= '0;
    else if (!pin)         hi_cnt <= '0;
    else if (hi_cnt != CMAX) hi_cnt <= hi_cnt + 1'b1;
  end

  assign qual = pin && (hi_cnt == CMAX);

  // R1: a qualified pin is preceded by a high pin on the previous cycle
  p_qual_needs_history_r1: assert property (@(posedge clk) disable iff (!por_n)
    qual |-> $past(pin));
endmodule

// File: rtl/rst_timer.sv
module rst_timer
  import chip_rst_seq_pkg::*;
#(
  parameter int LONG_TICKS  = 4100,
  parameter int SHORT_TICKS = 16,
  parameter int BRN_TICKS   = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic slow_tick,
  input  logic req_pin,
  input  logic req_ctrl,
  input  logic sys_pwr,
  output logic busy,
  output logic start,
  output logic brn
);
  localparam int TMAX = (LONG_TICKS > SHORT_TICKS) ?
                        ((LONG_TICKS > BRN_TICKS) ? LONG_TICKS : BRN_TICKS) :
                        ((SHORT_TICKS > BRN_TICKS) ? SHORT_TICKS : BRN_TICKS);
  localparam int TW = $clog2(TMAX + 1);

  logic [TW-1:0] cnt;
  len_cls_e      cls;
  logic          brn_pend;
  logic [TW-1:0] last_idx;
  req_src_e      src;

  always_comb begin
    if (req_pin)       src = SRC_PIN;
    else if (req_ctrl) src = SRC_CTRL;
    else               src = SRC_NONE;
  end

  always_comb begin
    unique case (cls)
      LEN_SHORT: last_idx = TW'(SHORT_TICKS - 1);
      LEN_BRN:   last_idx = TW'(BRN_TICKS - 1);
      default:   last_idx = TW'(LONG_TICKS - 1);
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy     <= 1'b1;
      cnt      <= '0;
      cls      <= LEN_LONG;
      brn_pend <= 1'b0;
      start    <= 1'b0;
      brn      <= 1'b0;
    end else begin
      start <= 1'b0;
      if (src != SRC_NONE) begin
        busy     <= 1'b1;
        cnt      <= '0;
        cls      <= pick_len(src, sys_pwr);
        brn_pend <= !sys_pwr;
      end else if (busy && slow_tick) begin
        if (cnt == last_idx) begin
          busy  <= 1'b0;
          cnt   <= '0;
          start <= 1'b1;
          brn   <= brn_pend;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: the start strobe lasts a single cycle
  p_start_single_r4: assert property (@(posedge clk) disable iff (!por_n)
    start |=> !start);
  // R7: any request restarts the count from zero
  p_restart_r7: assert property (@(posedge clk) disable iff (!por_n)
    (req_pin || req_ctrl) |=> (busy && cnt == '0));
  // R6: brownout only changes together with a start strobe
  p_brn_at_start_r6: assert property (@(posedge clk) disable iff (!por_n)
    !start |-> $stable(brn));
endmodule

// File: rtl/wdt_sticky.sv
module wdt_sticky (
  input  logic clk,
  input  logic por_n,
  input  logic ovf,
  input  logic dis,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           flag <= 1'b0;
    else if (clr)         flag <= 1'b0;
    else if (ovf && !dis) flag <= 1'b1;
  end

  // R9: a masked overflow leaves the flag alone
  p_masked_ovf_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!clr && (!ovf || dis)) |=> $stable(flag));
  // R10: a qualified pin clears the flag, winning over a set
  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> !flag);
endmodule

// File: rtl/chip_rst_seq.sv
module chip_rst_seq #(
  parameter int QUAL_CYC    = 100,
  parameter int LONG_TICKS  = 4100,
  parameter int SHORT_TICKS = 16,
  parameter int BRN_TICKS   = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic slow_tick,
  input  logic rst_pin,
  input  logic rst_bit,
  input  logic test_pin,
  input  logic dbg_rst_n,
  input  logic sys_pwr,
  input  logic wdt_ovf,
  input  logic wdt_dis,
  output logic regs_rst,
  output logic rtc_rst,
  output logic cpu_rst,
  output logic cpu_start,
  output logic brownout,
  output logic wdt_flag
);
  logic pin_q;
  logic tmr_busy;

  rst_pin_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .por_n(por_n), .pin(rst_pin), .qual(pin_q)
  );

  rst_timer #(
    .LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS), .BRN_TICKS(BRN_TICKS)
  ) u_tmr (
    .clk(clk), .por_n(por_n), .slow_tick(slow_tick),
    .req_pin(pin_q), .req_ctrl(rst_bit), .sys_pwr(sys_pwr),
    .busy(tmr_busy), .start(cpu_start), .brn(brownout)
  );

  wdt_sticky u_wdt (
    .clk(clk), .por_n(por_n), .ovf(wdt_ovf), .dis(wdt_dis),
    .clr(pin_q), .flag(wdt_flag)
  );

  assign regs_rst = tmr_busy || pin_q || rst_bit;
  assign rtc_rst  = pin_q && test_pin;
  assign cpu_rst  = regs_rst || !dbg_rst_n;

  // R3: RTC reset implies the register file is in reset as well
  p_rtc_inside_regs_r3: assert property (@(posedge clk) disable iff (!por_n)
    rtc_rst |-> regs_rst);
  // R8: debug soft reset always holds the core
  p_dbg_holds_core_r8: assert property (@(posedge clk) disable iff (!por_n)
    !dbg_rst_n |-> cpu_rst);
  // R4: the core is released on the strobe cycle unless debug holds it
  p_start_releases_r4: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_start && dbg_rst_n) |-> !cpu_rst);
endmodule

// File: tb/sim_chip_rst_seq.sv
module sim_chip_rst_seq;
  localparam int Q  = 4;
  localparam int LT = 20;
  localparam int ST = 5;
  localparam int BT = 2;

  logic clk = 1'b0;
  logic por_n = 1'b0, slow_tick = 1'b0, rst_pin = 1'b0, rst_bit = 1'b0;
  logic test_pin = 1'b0, dbg_rst_n = 1'b1, sys_pwr = 1'b1;
  logic wdt_ovf = 1'b0, wdt_dis = 1'b0;
  logic regs_rst, rtc_rst, cpu_rst, cpu_start, brownout, wdt_flag;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R11";

  // behavioural reference state
  int  qc = 0, m_cnt = 0, m_len = LT;
  bit  m_busy = 1, m_start = 0, m_brn = 0, m_brn_nx = 0, m_flag = 0;

  always #10 clk = ~clk;

  chip_rst_seq #(.QUAL_CYC(Q), .LONG_TICKS(LT), .SHORT_TICKS(ST), .BRN_TICKS(BT)) u0 (
    .clk(clk), .por_n(por_n), .slow_tick(slow_tick), .rst_pin(rst_pin),
    .rst_bit(rst_bit), .test_pin(test_pin), .dbg_rst_n(dbg_rst_n),
    .sys_pwr(sys_pwr), .wdt_ovf(wdt_ovf), .wdt_dis(wdt_dis),
    .regs_rst(regs_rst), .rtc_rst(rtc_rst), .cpu_rst(cpu_rst),
    .cpu_start(cpu_start), .brownout(brownout), .wdt_flag(wdt_flag)
  );

  // slow tick every third clock, driven after the edge
  always @(posedge clk) begin
    cyc++;
    #1 slow_tick = (cyc % 3 == 0);
  end

  // reference model update on each edge
  always @(posedge clk) begin
    bit pq, req;
    if (por_n) begin
      pq  = rst_pin && (qc >= Q);
      req = pq || rst_bit;
      if (pq) m_flag = 0;
      else if (wdt_ovf && !wdt_dis) m_flag = 1;
      m_start = 0;
      if (req) begin
        m_busy = 1; m_cnt = 0;
        m_len = !sys_pwr ? BT : (pq ? LT : ST);
        m_brn_nx = !sys_pwr;
      end else if (m_busy && slow_tick) begin
        m_cnt++;
        if (m_cnt == m_len) begin
          m_busy = 0; m_cnt = 0; m_start = 1; m_brn = m_brn_nx;
        end
      end
      qc = rst_pin ? ((qc < Q) ? qc + 1 : Q) : 0;
    end
  end

  task automatic chk(input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit pq, ex_regs;
    if (por_n) begin
      pq = rst_pin && (qc >= Q);
      ex_regs = m_busy || pq || rst_bit;
      chk("regs_rst (R2)", regs_rst, ex_regs);
      chk("rtc_rst (R3)", rtc_rst, pq && test_pin);
      chk("cpu_rst (R8)", cpu_rst, ex_regs || !dbg_rst_n);
      chk("cpu_start", cpu_start, m_start);
      chk("brownout (R6)", brownout, m_brn);
      chk("wdt_flag", wdt_flag, m_flag);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    step(3);
    // reset state while por_n is low
    tag = "R11";
    chk("regs_rst at por", regs_rst, 1'b1);
    chk("cpu_start at por", cpu_start, 1'b0);
    chk("wdt_flag at por", wdt_flag, 1'b0);
    por_n = 1'b1;
    step(75);
    tag = "R1";  rst_pin = 1'b1; step(Q - 1); rst_pin = 1'b0; step(8);
    tag = "R1";  rst_pin = 1'b1; step(Q - 1); rst_pin = 1'b0; step(4);
    tag = "R9";  wdt_dis = 1'b1; wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0; step(3);
    wdt_dis = 1'b0; wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0; step(3);
    tag = "R10"; rst_bit = 1'b1; step(2); rst_bit = 1'b0;
    tag = "R5";  step(25);
    tag = "R3";  test_pin = 1'b1; rst_pin = 1'b1; wdt_ovf = 1'b1; step(Q + 3);
    wdt_ovf = 1'b0; rst_pin = 1'b0; test_pin = 1'b0;
    tag = "R4";  step(70);
    tag = "R6";  sys_pwr = 1'b0; rst_bit = 1'b1; step(2); rst_bit = 1'b0; step(15);
    rst_pin = 1'b1; step(Q + 2); rst_pin = 1'b0; step(15); sys_pwr = 1'b1;
    tag = "R7";  rst_bit = 1'b1; step(1); rst_bit = 1'b0; step(7);
    rst_bit = 1'b1; step(1); rst_bit = 1'b0; step(25);
    tag = "R8";  dbg_rst_n = 1'b0; step(5); dbg_rst_n = 1'b1; step(2);
    rst_bit = 1'b1; step(1); rst_bit = 1'b0; step(3);
    dbg_rst_n = 1'b0; step(4); dbg_rst_n = 1'b1; step(20);
    tag = "R5";  rst_bit = 1'b1; rst_pin = 1'b1; step(Q + 1); rst_bit = 1'b0; rst_pin = 1'b0;
    step(70);
    finish_run();
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule